// File: doc/BRIEF.md
# Scan-Configured Four-Neighbour Lookup Cell Tile

This block is a rectangular tile of identical logic cells. Each cell sits on a grid. It receives one bit from each of its four neighbours (north, east, south, west) and sends one bit back toward each of them. The bit sent in each direction is an arbitrary boolean function of the four received bits, defined by a 16-entry truth table. The data path has no clock: a change on a tile edge input ripples through the cells combinationally.

The four truth tables of a cell form a 64-bit word. All words are loaded through one serial chain that visits every cell. The chain has a serial data input and output and a forwarded shift clock, so several tiles can be cascaded. Each cell keeps two copies of its word. The shift copy moves on every shift clock edge. The applied copy is a set of level-sensitive latches that drives the logic. While the keep control is high, the applied copy is frozen, so a new configuration can be scanned in while the array keeps running on the old one. Driving keep low makes the applied copy take the shift copy.

Cells on the border take their missing neighbour from the matching tile edge input and drive their outward bit onto the matching tile edge output. Every cell in row 0 sees `north_i[c]` as its north neighbour and drives `north_o[c]`. Row ROWS-1 does the same with `south_i`/`south_o`. Column 0 uses `west_i[r]`/`west_o[r]`, and column COLS-1 uses `east_i[r]`/`east_o[r]`.

Top module: `lut_tile`

## Requirements
- R1: A synchronous active-high reset on a shift clock edge clears both the shift copy and the applied copy of every cell. After reset, all edge outputs and `scan_o` are 0.
- R2: A cell's truth-table index is the 4-bit value {N, E, S, W}, with the north input as bit 3 and the west input as bit 0. The output equals the table bit at that index.
- R3: While `keep_i` is high, shifting the chain does not change any edge output. The outputs depend only on the applied tables and the edge inputs.
- R4: While `keep_i` is low, the applied copy takes the shift copy. After keep returns high, the new functions drive the outputs.
- R5: The chain visits cells in raster order, index r*COLS+c, starting at row 0 column 0. `scan_i` enters bit 0 of cell 0. Each cell shifts toward its bit 63, and bit 63 feeds the next cell. `scan_o` therefore repeats `scan_i` delayed by ROWS*COLS*64 shift clocks.
- R6: `sclk_o` is the shift clock `sclk_i` forwarded for the next tile in the chain.
- R7: Neighbour wiring follows the grid. A cell's south output is the north input of the cell below it, and its east output is the west input of the cell to its right. Border cells use the edge ports as described above.
- R8: Word field positions are fixed. Bits [15:0] are the north table, [31:16] the east table, [47:32] the south table and [63:48] the west table.
- R9: A reset applied while the tile is running clears the functions immediately. With any edge inputs, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Shift clock for the configuration chain |
| rst_i | input | 1 | Synchronous active-high reset, sampled on `sclk_i` |
| keep_i | input | 1 | High: applied tables frozen; low: applied tables follow the chain |
| scan_i | input | 1 | Serial configuration data in |
| sclk_o | output | 1 | Forwarded shift clock |
| scan_o | output | 1 | Serial configuration data out (last cell, bit 63) |
| north_i | input | COLS | North edge inputs, one per column |
| south_i | input | COLS | South edge inputs, one per column |
| east_i | input | ROWS | East edge inputs, one per row |
| west_i | input | ROWS | West edge inputs, one per row |
| north_o | output | COLS | North edge outputs from row 0 |
| south_o | output | COLS | South edge outputs from the last row |
| east_o | output | ROWS | East edge outputs from the last column |
| west_o | output | ROWS | West edge outputs from column 0 |

## Verification
The bench builds the tile with ROWS=2 and COLS=3, giving six cells and a 384-bit chain. The two dimensions differ, so a swap of rows and columns, or of the raster order, moves a function to a visibly wrong edge. At this size every cell touches at least one edge and a full reload takes a few hundred clocks. That makes it cheap to check all four table fields, readback of a previous load through `scan_o`, and the frozen-versus-applied behaviour against a bench model of the whole grid. The functions are chosen so that signals flowing toward the south-east depend only on north and west inputs, and signals flowing toward the north-west depend only on east and south inputs. This keeps the array free of combinational loops while still exercising every neighbour link.

// File: rtl/lut_tile_pkg.sv
package lut_tile_pkg;
  localparam int TT_W  = 16;            // truth table entries per output
  localparam int DIRS  = 4;             // neighbour directions
  localparam int CFG_W = TT_W * DIRS;   // bits per cell word
  // direction slots; also the table field order inside a cell word (R8)
  typedef enum int {D_N = 0, D_E = 1, D_S = 2, D_W = 3} dir_e;
endpackage

// File: rtl/lut4.sv
module lut4 #(
  parameter int TT_W = 16,
  localparam int SEL_W = $clog2(TT_W)
) (
  input  logic [TT_W-1:0]  table_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             y_o
);
  assign y_o = table_i[sel_i];
endmodule

// File: rtl/cfg_store.sv
module cfg_store #(
  parameter int W = 64
) (
  input  logic         sclk_i,
  input  logic         rst_i,
  input  logic         keep_i,
  input  logic         sdi_i,
  output logic         sdo_o,
  output logic [W-1:0] shadow_o,
  output logic [W-1:0] live_o
);
  logic [W-1:0] sh_q;
  logic [W-1:0] live_q;

  // shift copy: new bit enters at bit 0, leaves from bit W-1
  always_ff @(posedge sclk_i) begin
    if (rst_i) sh_q <= '0;
    else       sh_q <= {sh_q[W-2:0], sdi_i};
  end

  // applied copy: level-sensitive, transparent while keep is low
  always_latch begin
    if (rst_i)       live_q <= '0;
    else if (!keep_i) live_q <= sh_q;
  end

  assign sdo_o    = sh_q[W-1];
  assign shadow_o = sh_q;
  assign live_o   = live_q;
endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_tile_pkg::*;
(
  input  logic             sclk_i,
  input  logic             rst_i,
  input  logic             keep_i,
  input  logic             sdi_i,
  output logic             sdo_o,
  input  logic [DIRS-1:0]  nbr_i,   // indexed by dir_e
  output logic [DIRS-1:0]  nbr_o,   // indexed by dir_e
  output logic [CFG_W-1:0] shadow_o,
  output logic [CFG_W-1:0] live_o
);
  localparam int SEL_W = $clog2(TT_W);
  logic [SEL_W-1:0] idx;
  logic [CFG_W-1:0] live;

  cfg_store #(.W(CFG_W)) u_store (
    .sclk_i  (sclk_i),
    .rst_i   (rst_i),
    .keep_i  (keep_i),
    .sdi_i   (sdi_i),
    .sdo_o   (sdo_o),
    .shadow_o(shadow_o),
    .live_o  (live)
  );

  // table index: north is the MSB, west the LSB
  assign idx = {nbr_i[D_N], nbr_i[D_E], nbr_i[D_S], nbr_i[D_W]};

  for (genvar d = 0; d < DIRS; d++) begin : g_dir
    lut4 #(.TT_W(TT_W)) u_lut (
      .table_i(live[d*TT_W +: TT_W]),
      .sel_i  (idx),
      .y_o    (nbr_o[d])
    );
  end

  assign live_o = live;
endmodule

// File: rtl/lut_tile.sv
module lut_tile
  import lut_tile_pkg::*;
#(
  parameter int ROWS = 2,
  parameter int COLS = 3
) (
  input  logic            sclk_i,
  input  logic            rst_i,
  input  logic            keep_i,
  input  logic            scan_i,
  output logic            sclk_o,
  output logic            scan_o,
  input  logic [COLS-1:0] north_i,
  input  logic [COLS-1:0] south_i,
  input  logic [ROWS-1:0] east_i,
  input  logic [ROWS-1:0] west_i,
  output logic [COLS-1:0] north_o,
  output logic [COLS-1:0] south_o,
  output logic [ROWS-1:0] east_o,
  output logic [ROWS-1:0] west_o
);
  localparam int CELLS = ROWS * COLS;

  logic [CELLS:0]         link;
  logic [CELLS-1:0]       in_n, in_e, in_s, in_w;
  logic [CELLS-1:0]       to_n, to_e, to_s, to_w;
  logic [CELLS*CFG_W-1:0] cfg_shadow;
  logic [CELLS*CFG_W-1:0] cfg_live;

  assign link[0] = scan_i;
  assign scan_o  = link[CELLS];
  assign sclk_o  = sclk_i;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int K = r * COLS + c;

      if (r == 0) begin : g_ntop
        assign in_n[K] = north_i[c];
      end else begin : g_nin
        assign in_n[K] = to_s[K-COLS];
      end
      if (r == ROWS-1) begin : g_sbot
        assign in_s[K] = south_i[c];
      end else begin : g_sin
        assign in_s[K] = to_n[K+COLS];
      end
      if (c == 0) begin : g_wleft
        assign in_w[K] = west_i[r];
      end else begin : g_win
        assign in_w[K] = to_e[K-1];
      end
      if (c == COLS-1) begin : g_eright
        assign in_e[K] = east_i[r];
      end else begin : g_ein
        assign in_e[K] = to_w[K+1];
      end

      lut_cell u_cell (
        .sclk_i  (sclk_i),
        .rst_i   (rst_i),
        .keep_i  (keep_i),
        .sdi_i   (link[K]),
        .sdo_o   (link[K+1]),
        .nbr_i   ({in_w[K], in_s[K], in_e[K], in_n[K]}),
        .nbr_o   ({to_w[K], to_s[K], to_e[K], to_n[K]}),
        .shadow_o(cfg_shadow[K*CFG_W +: CFG_W]),
        .live_o  (cfg_live[K*CFG_W +: CFG_W])
      );
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_edge_ns
    assign north_o[c] = to_n[c];
    assign south_o[c] = to_s[(ROWS-1)*COLS + c];
  end
  for (genvar r = 0; r < ROWS; r++) begin : g_edge_ew
    assign west_o[r] = to_w[r*COLS];
    assign east_o[r] = to_e[r*COLS + COLS-1];
  end
endmodule

// File: rtl/lut_tile_chk.sv
module lut_tile_chk
  import lut_tile_pkg::*;
#(
  parameter int ROWS = 2,
  parameter int COLS = 3,
  localparam int CELLS = ROWS * COLS,
  localparam int EDGE  = 2 * (ROWS + COLS)
) (
  input logic                   sclk_i,
  input logic                   rst_i,
  input logic                   scan_i,
  input logic                   scan_o,
  input logic [EDGE-1:0]        edge_in,
  input logic [EDGE-1:0]        edge_out,
  input logic [CELLS*CFG_W-1:0] shadow,
  input logic [CELLS*CFG_W-1:0] live
);
  // R1: first edge after reset release sees a cleared tile
  a_r1_clean_after_reset: assert property (@(posedge sclk_i) disable iff (rst_i)
    $fell(rst_i) |-> (edge_out == '0 && scan_o == 1'b0));

  // R1: all-zero applied tables give all-zero outputs
  a_r1_zero_tables: assert property (@(posedge sclk_i) disable iff (rst_i)
    (live == '0) |-> (edge_out == '0));

  // R3: outputs depend only on applied tables and edge inputs
  a_r3_no_shift_effect: assert property (@(posedge sclk_i) disable iff (rst_i)
    ($stable(live) && $stable(edge_in)) |-> $stable(edge_out));

  // R5: serial data enters bit 0 of the first cell
  a_r5_entry: assert property (@(posedge sclk_i) disable iff (rst_i)
    !rst_i |=> (shadow[0] == $past(scan_i)));

  // R5: bit 63 of each cell feeds bit 0 of the next
  for (genvar k = 0; k < CELLS-1; k++) begin : g_hop
    a_r5_hop: assert property (@(posedge sclk_i) disable iff (rst_i)
      !rst_i |=> (shadow[(k+1)*CFG_W] == $past(shadow[k*CFG_W + CFG_W-1])));
  end
endmodule

bind lut_tile lut_tile_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .sclk_i  (sclk_i),
  .rst_i   (rst_i),
  .scan_i  (scan_i),
  .scan_o  (scan_o),
  .edge_in ({north_i, south_i, east_i, west_i}),
  .edge_out({north_o, south_o, east_o, west_o}),
  .shadow  (cfg_shadow),
  .live    (cfg_live)
);

// File: tb/lut_tile_tb.sv
module lut_tile_tb;
  localparam int ROWS  = 2;
  localparam int COLS  = 3;
  localparam int CELLS = ROWS * COLS;
  localparam int CHAIN = CELLS * 64;
  localparam int NV    = 12;
  localparam logic [9:0] STIM [NV] = '{10'h000, 10'h3FF, 10'h155, 10'h2AA,
    10'h0F0, 10'h30F, 10'h081, 10'h246, 10'h1C3, 10'h3A5, 10'h05A, 10'h2D1};

  logic clk = 0;
  logic run_en = 1;
  logic rst = 1;
  logic keep = 1;
  logic scan_in = 0;
  logic [9:0] st = '0;
  wire sclk = clk & run_en;
  wire sclk_out, scan_out;
  wire [COLS-1:0] n_o, s_o;
  wire [ROWS-1:0] e_o, w_o;
  wire [9:0] outs = {n_o, s_o, e_o, w_o};

  int total = 0, bad = 0, cyc = 0, rb_err = 0;
  bit done = 0;
  logic [63:0] cfg_m [CELLS];   // applied model
  logic [63:0] cfg_n [CELLS];   // pending (shifted) model
  logic [CHAIN-1:0] prev_stream = '0, cur_stream = '0;

  lut_tile #(.ROWS(ROWS), .COLS(COLS)) u_dut (
    .sclk_i(sclk), .rst_i(rst), .keep_i(keep), .scan_i(scan_in),
    .sclk_o(sclk_out), .scan_o(scan_out),
    .north_i(st[9:7]), .south_i(st[6:4]), .east_i(st[3:2]), .west_i(st[1:0]),
    .north_o(n_o), .south_o(s_o), .east_o(e_o), .west_o(w_o)
  );

  always #10 clk = ~clk;

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
      summary();
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic op(int code, logic a, logic b);
    case (code)
      0: return a ^ b;
      1: return a & b;
      2: return a | b;
      3: return ~(a ^ b);
      4: return a;
      5: return b;
      6: return ~a;
      default: return a & ~b;
    endcase
  endfunction

  // north/west tables use (E,S); east/south tables use (N,W): no loops
  function automatic logic [63:0] mk_cfg(int seed, int k);
    logic [63:0] w = '0;
    for (int d = 0; d < 4; d++) begin
      int code = (k * 3 + d * 5 + seed) % 8;
      for (int i = 0; i < 16; i++) begin
        logic n = i[3], e = i[2], s = i[1], wi = i[0];
        w[d*16 + i] = (d == 0 || d == 3) ? op(code, e, s) : op(code, n, wi);
      end
    end
    return w;
  endfunction

  function automatic logic [9:0] model(logic [9:0] x);
    logic [CELLS-1:0] on = '0, oe = '0, os = '0, ow = '0;
    for (int p = 0; p < 8; p++) begin
      for (int r = 0; r < ROWS; r++) begin
        for (int c = 0; c < COLS; c++) begin
          int k = r * COLS + c;
          logic n, e, s, w;
          logic [3:0] ix;
          if (r == 0) n = x[7+c]; else n = os[k-COLS];
          if (r == ROWS-1) s = x[4+c]; else s = on[k+COLS];
          if (c == 0) w = x[r]; else w = oe[k-1];
          if (c == COLS-1) e = x[2+r]; else e = ow[k+1];
          ix = {n, e, s, w};
          on[k] = cfg_m[k][ix];
          oe[k] = cfg_m[k][16 + ix];
          os[k] = cfg_m[k][32 + ix];
          ow[k] = cfg_m[k][48 + ix];
        end
      end
    end
    return {on[2], on[1], on[0], os[5], os[4], os[3],
            oe[5], oe[2], ow[3], ow[0]};
  endfunction

  // shift cfg_n into the chain, last cell first, bit 63 first
  task automatic push_stream();
    int j = 0;
    rb_err = 0;
    for (int k = CELLS-1; k >= 0; k--) begin
      for (int b = 63; b >= 0; b--) begin
        @(negedge clk);
        if (scan_out !== prev_stream[j]) rb_err++;
        scan_in = cfg_n[k][b];
        cur_stream[j] = cfg_n[k][b];
        run_en = 1;
        j++;
      end
    end
    @(negedge clk);
    run_en = 0;
    prev_stream = cur_stream;
  endtask

  task automatic apply();
    @(negedge clk); keep = 0;
    @(negedge clk); keep = 1;
    for (int k = 0; k < CELLS; k++) cfg_m[k] = cfg_n[k];
  endtask

  task automatic drive(logic [9:0] v);
    @(negedge clk); st = v; #2;
  endtask

  initial begin
    for (int k = 0; k < CELLS; k++) begin cfg_m[k] = '0; cfg_n[k] = '0; end
    // reset with running shift clock
    repeat (2) @(negedge clk);
    @(posedge clk); #2;
    check("R6 forwarded clock high", sclk_out, 1'b1);
    @(negedge clk); #2;
    check("R6 forwarded clock low", sclk_out, 1'b0);
    rst = 0; run_en = 0;
    drive(10'h3FF);
    check("R1 outputs after reset", outs, 10'h000);
    check("R1 scan_o after reset", scan_out, 1'b0);

    // R2: cell 0 north table = bit 9 only -> north_o[0] = N & W
    cfg_n[0] = 64'h0000_0000_0000_0200;
    push_stream();
    check("R5 readback after reset", rb_err, 0);
    apply();
    for (int q = 0; q < 4; q++) begin
      logic nn = q[1], ww = q[0];
      drive({2'b00, nn, 3'b000, 2'b00, 1'b0, ww});
      check("R2 index N,W -> north_o", outs, {7'b0, nn & ww, 2'b00} << 0 == 0 ?
            10'h000 : {2'b00, nn & ww, 7'b0});
    end

    // R8: field positions, also raster order of R5
    for (int k = 0; k < CELLS; k++) cfg_n[k] = '0;
    cfg_n[0] = 64'hFFFF_0000_0000_0000;   // west field of cell (0,0)
    cfg_n[5] = 64'h0000_0000_FFFF_0000;   // east field of cell (1,2)
    cfg_n[3] = 64'h0000_FFFF_0000_0000;   // south field of cell (1,0)
    cfg_n[2] = 64'h0000_0000_0000_FFFF;   // north field of cell (0,2)
    push_stream();
    check("R5 readback of previous load", rb_err, 0);
    apply();
    drive(10'h000);
    check("R8 west field -> west_o", w_o, 2'b01);
    check("R8 east field -> east_o", e_o, 2'b10);
    check("R8 south field -> south_o", s_o, 3'b001);
    check("R8 north field -> north_o", n_o, 3'b100);

    // R7/R2: full grid against the model, table walk
    for (int k = 0; k < CELLS; k++) cfg_n[k] = mk_cfg(1, k);
    push_stream();
    apply();
    for (int v = 0; v < NV; v++) begin
      drive(STIM[v]);
      check("R7 grid vector", outs, model(STIM[v]));
    end

    // R3: shift a new set with keep high; outputs keep old functions
    for (int k = 0; k < CELLS; k++) cfg_n[k] = mk_cfg(6, k);
    drive(STIM[2]);
    push_stream();
    check("R5 readback of applied set", rb_err, 0);
    for (int v = 0; v < 4; v++) begin
      drive(STIM[v+4]);
      check("R3 old functions kept while shifting", outs, model(STIM[v+4]));
    end

    // R4: apply the pending set
    apply();
    for (int v = 0; v < NV; v++) begin
      drive(STIM[v]);
      check("R4 new functions after apply", outs, model(STIM[v]));
    end

    // R9: reset while running
    drive(10'h3FF);
    @(negedge clk); rst = 1; run_en = 1;
    @(negedge clk); run_en = 0; #2;
    check("R9 outputs cleared by reset", outs, 10'h000);
    rst = 0;
    apply();
    drive(10'h155);
    check("R9 shift copy also cleared", outs, 10'h000);
    check("R9 scan_o cleared", scan_out, 1'b0);

    summary();
  end
endmodule